// File: doc/BRIEF.md
# ROM Integrity Checker

The block is a self-test engine for one read-only memory block that sits at a fixed base address in a wider address space. A single start pulse runs three checks, one after the other, over a read port with one cycle of latency. The first check drives the data bus. The second confirms the block sits at the expected base address. The third computes a 16-bit rotate-and-add checksum and compares it with a value stored in the block itself. When the run ends the engine holds a done flag, a pass flag and a 2-bit failure code until the next run starts.

The block is laid out as follows, with offsets counted from the base address:
- Offsets 0 and 1 hold a pattern and its bitwise complement.
- Offset 2 holds the upper eight bits of the base address.
- The last two offsets hold the expected checksum, high byte first.

The checksum covers every byte before those last two. The engine stops at the first check that fails.

The controller is a state machine with five states:
- `S_IDLE`: the state after reset.
- `S_BUS`: reads offsets 0 and 1.
- `S_PLACE`: reads offset 2.
- `S_SUM`: streams the whole block.
- `S_DONE`: holds the result.

It has these transitions:
- `S_IDLE`/`S_DONE` → `S_BUS` on start.
- `S_BUS` → `S_PLACE` when the complement test holds, or `S_BUS` → `S_DONE` with code 1 when it does not.
- `S_PLACE` → `S_SUM` when the byte matches, or `S_PLACE` → `S_DONE` with code 2 when it does not.
- `S_SUM` → `S_DONE` with code 0 or 3 after the last byte returns.

Top module: `rom_chk_top`

## Requirements
- R1: After reset, done, pass, rd_en and fail_code are all 0.
- R2: A start seen in `S_IDLE` or `S_DONE` begins a run and clears done, pass and fail_code on the next cycle. A start seen during a run is ignored and changes neither its result nor its timing.
- R3: A read asserts rd_en with rd_addr = BASE_ADDR + offset. rd_data is sampled one cycle later. Every address issued lies within BASE_ADDR to BASE_ADDR + ROM_BYTES - 1, and no read is issued outside a run.
- R4: The bytes at offsets 0 and 1 must be exact bitwise complements of each other. If they are not, the run ends with fail_code = 1.
- R5: The byte at offset 2 must equal bits [ADDR_W-1:ADDR_W-8] of BASE_ADDR. If it does not, the run ends with fail_code = 2.
- R6: The checksum works as follows:
  - The accumulator starts at 0x0000.
  - For each byte at offsets 0 to ROM_BYTES-3, in ascending order, it is rotated left by one bit and the byte is then added modulo 2^16.
  - The result is compared with {byte[ROM_BYTES-2], byte[ROM_BYTES-1]}.
  - On a mismatch the run ends with fail_code = 3.
- R7: The checks run in the order bus, placement, checksum, and the code reported is that of the first failing check.
- R8: When all three checks hold, done and pass are both 1 and fail_code = 0. When done is 1 and pass is 0, fail_code is nonzero.
- R9: Once done is 1, done, pass and fail_code stay unchanged until a start is accepted.
- R10: Counting clock edges from the edge that samples start, done is first 1 after edge 3 on a bus failure, after edge 5 on a placement failure, and after edge ROM_BYTES + 6 when the run reaches the checksum compare.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Start pulse for a run |
| rd_en | output | 1 | Read request to the ROM |
| rd_addr | output | ADDR_W | Absolute read address |
| rd_data | input | 8 | Read byte, valid one cycle after rd_en |
| done | output | 1 | Run finished; held until the next start |
| pass | output | 1 | All checks held |
| fail_code | output | 2 | 0 none, 1 bus, 2 placement, 3 checksum |

## Verification
A wrong state transition shows at the ports as a wrong fail_code, or as done rising on the wrong edge. Because the completion edge of each outcome is fixed, a stuck or skipped state is visible within a few cycles of the expected edge. A corrupted accumulator or offset register cannot hide: single-bit flips across every byte of a small block make any wrong accumulator step change the reported code. The address bounds are watched on every read, so a stray or repeated read is caught on the cycle it is issued.

// File: rtl/rom_chk_pkg.sv
package rom_chk_pkg;

    typedef enum logic [2:0] {
        S_IDLE,
        S_BUS,
        S_PLACE,
        S_SUM,
        S_DONE
    } chk_state_t;

    localparam logic [1:0] FC_NONE  = 2'd0;
    localparam logic [1:0] FC_BUS   = 2'd1;
    localparam logic [1:0] FC_PLACE = 2'd2;
    localparam logic [1:0] FC_SUM   = 2'd3;

endpackage

// File: rtl/rom_chk_addr_gen.sv
module rom_chk_addr_gen #(
    parameter int                 ADDR_W    = 16,
    parameter int                 OFF_W     = 8,
    parameter logic [ADDR_W-1:0]  BASE_ADDR = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [OFF_W-1:0]  load_off,
    input  logic              issue,
    output logic [OFF_W-1:0]  off,
    output logic [ADDR_W-1:0] rd_addr,
    output logic              rvalid,
    output logic [OFF_W-1:0]  roff
);

    // Offset of the next read; the return pipe tracks the read in flight.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            off    <= '0;
            rvalid <= 1'b0;
            roff   <= '0;
        end else begin
            if (load)
                off <= load_off;
            else if (issue)
                off <= off + 1'b1;
            rvalid <= issue;
            if (issue)
                roff <= off;
        end
    end

    assign rd_addr = BASE_ADDR + ADDR_W'(off);

endmodule

// File: rtl/rom_chk_spiral.sv
module rom_chk_spiral #(
    parameter int SUM_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             en,
    input  logic [7:0]       din,
    output logic [SUM_W-1:0] acc
);

    logic [SUM_W-1:0] rotated;

    // Rotate left by one, then add the byte; the carry out is dropped.
    assign rotated = {acc[SUM_W-2:0], acc[SUM_W-1]};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            acc <= '0;
        else if (clr)
            acc <= '0;
        else if (en)
            acc <= rotated + SUM_W'(din);
    end

endmodule

// File: rtl/rom_chk_top.sv
module rom_chk_top
    import rom_chk_pkg::*;
#(
    parameter int                 ADDR_W    = 16,
    parameter logic [ADDR_W-1:0]  BASE_ADDR = 16'hE000,
    parameter int                 ROM_BYTES = 256
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    output logic              rd_en,
    output logic [ADDR_W-1:0] rd_addr,
    input  logic [7:0]        rd_data,
    output logic              done,
    output logic              pass,
    output logic [1:0]        fail_code
);

    localparam int               OFF_W      = (ROM_BYTES > 2) ? $clog2(ROM_BYTES) : 1;
    localparam logic [OFF_W-1:0] OFF_PAT_A  = OFF_W'(0);
    localparam logic [OFF_W-1:0] OFF_PAT_B  = OFF_W'(1);
    localparam logic [OFF_W-1:0] OFF_PLACE  = OFF_W'(2);
    localparam logic [OFF_W-1:0] OFF_SUM_HI = OFF_W'(ROM_BYTES - 2);
    localparam logic [OFF_W-1:0] OFF_LAST   = OFF_W'(ROM_BYTES - 1);
    localparam logic [7:0]       PLACE_BYTE = BASE_ADDR[ADDR_W-1 -: 8];

    chk_state_t       state, state_nx;
    logic [1:0]       code_q;
    logic [7:0]       pat_q, sum_hi_q;
    logic             stage_done_q;
    logic [OFF_W-1:0] stage_last;
    logic             issue, load;
    logic [OFF_W-1:0] load_off;
    logic [OFF_W-1:0] off, roff;
    logic             rvalid;
    logic [15:0]      acc;
    logic             acc_en;
    logic             busy;
    logic             bus_ok, place_ok, sum_ok;
    logic             last_back;

    rom_chk_addr_gen #(
        .ADDR_W   (ADDR_W),
        .OFF_W    (OFF_W),
        .BASE_ADDR(BASE_ADDR)
    ) u_addr (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (load),
        .load_off(load_off),
        .issue   (issue),
        .off     (off),
        .rd_addr (rd_addr),
        .rvalid  (rvalid),
        .roff    (roff)
    );

    rom_chk_spiral #(
        .SUM_W(16)
    ) u_sum (
        .clk  (clk),
        .rst_n(rst_n),
        .clr  (load && (state != S_PLACE)),
        .en   (acc_en),
        .din  (rd_data),
        .acc  (acc)
    );

    // Last offset that each reading state must issue.
    always_comb begin
        unique case (state)
            S_BUS:   stage_last = OFF_PAT_B;
            S_PLACE: stage_last = OFF_PLACE;
            S_SUM:   stage_last = OFF_LAST;
            default: stage_last = '0;
        endcase
    end

    assign busy      = (state == S_BUS) || (state == S_PLACE) || (state == S_SUM);
    assign issue     = busy && !stage_done_q;
    assign last_back = rvalid && (roff == stage_last);
    assign acc_en    = (state == S_SUM) && rvalid && (roff < OFF_SUM_HI);
    assign bus_ok    = (rd_data == ~pat_q);
    assign place_ok  = (rd_data == PLACE_BYTE);
    assign sum_ok    = ({sum_hi_q, rd_data} == acc);

    // Next-state logic together with the offset loads.
    always_comb begin
        state_nx = state;
        load     = 1'b0;
        load_off = OFF_PAT_A;
        unique case (state)
            S_IDLE, S_DONE: begin
                if (start) begin
                    state_nx = S_BUS;
                    load     = 1'b1;
                    load_off = OFF_PAT_A;
                end
            end
            S_BUS: begin
                if (last_back) begin
                    if (bus_ok) begin
                        state_nx = S_PLACE;
                        load     = 1'b1;
                        load_off = OFF_PLACE;
                    end else begin
                        state_nx = S_DONE;
                    end
                end
            end
            S_PLACE: begin
                if (last_back) begin
                    if (place_ok) begin
                        state_nx = S_SUM;
                        load     = 1'b1;
                        load_off = OFF_PAT_A;
                    end else begin
                        state_nx = S_DONE;
                    end
                end
            end
            S_SUM: begin
                if (last_back)
                    state_nx = S_DONE;
            end
            default: state_nx = S_IDLE;
        endcase
    end

    // State register and the data it carries.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state        <= S_IDLE;
            code_q       <= FC_NONE;
            pat_q        <= '0;
            sum_hi_q     <= '0;
            stage_done_q <= 1'b0;
        end else begin
            state <= state_nx;
            if (load)
                stage_done_q <= 1'b0;
            else if (issue && (off == stage_last))
                stage_done_q <= 1'b1;
            if ((state == S_IDLE || state == S_DONE) && start)
                code_q <= FC_NONE;
            else if (last_back) begin
                unique case (state)
                    S_BUS:   if (!bus_ok)   code_q <= FC_BUS;
                    S_PLACE: if (!place_ok) code_q <= FC_PLACE;
                    S_SUM:   if (!sum_ok)   code_q <= FC_SUM;
                    default: ;
                endcase
            end
            if ((state == S_BUS) && rvalid && (roff == OFF_PAT_A))
                pat_q <= rd_data;
            if ((state == S_SUM) && rvalid && (roff == OFF_SUM_HI))
                sum_hi_q <= rd_data;
        end
    end

    // Outputs.
    always_comb begin
        rd_en     = issue;
        done      = (state == S_DONE);
        pass      = (state == S_DONE) && (code_q == FC_NONE);
        fail_code = code_q;
    end

endmodule

// File: rtl/rom_chk_sva.sv
module rom_chk_sva #(
    parameter int                 ADDR_W    = 16,
    parameter logic [ADDR_W-1:0]  BASE_ADDR = 16'hE000,
    parameter int                 ROM_BYTES = 256
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start,
    input logic              busy,
    input logic              rd_en,
    input logic [ADDR_W-1:0] rd_addr,
    input logic              done,
    input logic              pass,
    input logic [1:0]        fail_code
);

    localparam logic [ADDR_W-1:0] TOP_ADDR = BASE_ADDR + ADDR_W'(ROM_BYTES - 1);

    AST_ADDR_IN_BLOCK: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en |-> (rd_addr >= BASE_ADDR) && (rd_addr <= TOP_ADDR)); // R3

    AST_NO_READ_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !rd_en); // R3

    AST_START_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |=> (!done && !pass && (fail_code == 2'd0))); // R2

    AST_DONE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !start) |=> (done && $stable(pass) && $stable(fail_code))); // R9

    AST_PASS_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
        pass |-> (done && (fail_code == 2'd0))); // R8

    AST_FAIL_HAS_CODE: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !pass) |-> (fail_code != 2'd0)); // R8

endmodule

bind rom_chk_top rom_chk_sva #(
    .ADDR_W   (ADDR_W),
    .BASE_ADDR(BASE_ADDR),
    .ROM_BYTES(ROM_BYTES)
) u_rom_chk_sva (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .busy     (busy),
    .rd_en    (rd_en),
    .rd_addr  (rd_addr),
    .done     (done),
    .pass     (pass),
    .fail_code(fail_code)
);

// File: tb/test_rom_chk_top.sv
`timescale 1ns/1ps
module test_rom_chk_top;

    localparam int          AW   = 16;
    localparam logic [15:0] BASE = 16'hA700;
    localparam int          N    = 16;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic        rd_en;
    logic [15:0] rd_addr;
    logic [7:0]  rd_data = '0;
    logic        done, pass;
    logic [1:0]  fail_code;

    logic [7:0] rom [0:N-1];
    int checks = 0;
    int errors = 0;
    bit finished = 0;

    always #4 clk = ~clk;

    rom_chk_top #(.ADDR_W(AW), .BASE_ADDR(BASE), .ROM_BYTES(N)) i_rom_chk_top (
        .clk(clk), .rst_n(rst_n), .start(start), .rd_en(rd_en), .rd_addr(rd_addr),
        .rd_data(rd_data), .done(done), .pass(pass), .fail_code(fail_code)
    );

    // ROM model with one cycle of read latency.
    always @(posedge clk) begin
        logic [15:0] d;
        d = rd_addr - BASE;
        if (rd_en) begin
            rd_data <= rom[d[3:0]];
            checks++;
            if (rd_addr < BASE || rd_addr > BASE + 16'(N - 1)) begin
                errors++;
                $display("FAIL R3 address actual %h expected %h..%h", rd_addr, BASE, BASE + 16'(N - 1));
            end
        end
    end

    function automatic logic [15:0] spiral();
        logic [15:0] a = 16'h0000;
        for (int i = 0; i < N - 2; i++)
            a = {a[14:0], a[15]} + {8'h00, rom[i]};
        return a;
    endfunction

    function automatic logic [1:0] model_code();
        if (rom[1] != ~rom[0]) return 2'd1;
        if (rom[2] != BASE[15:8]) return 2'd2;
        if (spiral() != {rom[N-2], rom[N-1]}) return 2'd3;
        return 2'd0;
    endfunction

    function automatic int model_lat(logic [1:0] c);
        if (c == 2'd1) return 3;
        if (c == 2'd2) return 5;
        return N + 6;
    endfunction

    task automatic fill_good(int seed);
        logic [31:0] s = 32'(seed) * 32'd2654435761 + 32'd12345;
        logic [15:0] a;
        for (int i = 0; i < N; i++) begin
            s = s * 32'd1103515245 + 32'd12345;
            rom[i] = s[23:16];
        end
        rom[1] = ~rom[0];
        rom[2] = BASE[15:8];
        a = spiral();
        rom[N-2] = a[15:8];
        rom[N-1] = a[7:0];
    endtask

    task automatic check(bit ok, string tag, int act, int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // Run one check pass; poke>0 pulses start at that cycle during the run.
    task automatic run(string tag, int poke);
        logic [1:0] ec = model_code();
        int el = model_lat(ec);
        int lat = 0;
        @(negedge clk) start = 1'b1;
        @(posedge clk);
        @(negedge clk) start = 1'b0;
        check(!done && !pass && fail_code == 2'd0, "R2 clear after start", int'(done), 0);
        while (!done && lat < 100) begin
            @(posedge clk);
            @(negedge clk);
            lat++;
            start = (poke > 0 && lat == poke);
        end
        start = 1'b0;
        check(lat == el, {tag, " R10 latency"}, lat, el);
        check(fail_code == ec, {tag, " code"}, int'(fail_code), int'(ec));
        check(pass == (ec == 2'd0), {tag, " R8 pass"}, int'(pass), int'(ec == 2'd0));
    endtask

    initial begin
        #(8 * 150000);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog actual timeout expected finish");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < N; i++) rom[i] = '0;
        repeat (3) @(negedge clk);
        check(!done && !pass && !rd_en && fail_code == 2'd0, "R1 reset", int'(done), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(!done && !rd_en, "R1 after release", int'(done), 0);

        // Clean images: R6 checksum model agrees, R8 pass.
        for (int s = 0; s < 24; s++) begin
            fill_good(s);
            run("R6 R8 good", 0);
        end
        // Extreme contents.
        for (int v = 0; v < 2; v++) begin
            fill_good(0);
            for (int i = 3; i < N - 2; i++) rom[i] = v ? 8'hFF : 8'h00;
            begin
                logic [15:0] a = spiral();
                rom[N-2] = a[15:8];
                rom[N-1] = a[7:0];
            end
            run("R6 extreme", 0);
        end
        // R4 bus: every single-bit flip of either pattern byte.
        for (int o = 0; o < 2; o++)
            for (int b = 0; b < 8; b++) begin
                fill_good(100 + b);
                rom[o][b] = ~rom[o][b];
                run("R4 bus", 0);
            end
        // R5 placement.
        for (int b = 0; b < 8; b++) begin
            fill_good(200 + b);
            rom[2][b] = ~rom[2][b];
            run("R5 place", 0);
        end
        // R6 checksum: bit flips across summed and stored bytes.
        for (int o = 3; o < N; o++)
            for (int b = 0; b < 8; b++) begin
                fill_good(300 + o);
                rom[o][b] = ~rom[o][b];
                run("R6 sum", 0);
            end
        // R7 first failure wins.
        fill_good(400);
        rom[1] = rom[0];
        rom[2] = 8'h00;
        rom[N-1] = rom[N-1] ^ 8'h01;
        run("R7 bus before others", 0);
        fill_good(401);
        rom[2] = 8'h11;
        rom[N-1] = rom[N-1] ^ 8'h80;
        run("R7 place before sum", 0);
        // R2 start ignored mid-run.
        for (int p = 1; p < N + 5; p++) begin
            fill_good(500 + p);
            if (p[0]) rom[N-2] = rom[N-2] ^ 8'h04;
            run("R2 busy start", p);
        end
        // R9 hold.
        fill_good(600);
        rom[2] = 8'h00;
        run("R9 pre", 0);
        repeat (7) @(negedge clk);
        check(done && !pass && fail_code == 2'd2, "R9 hold", int'(fail_code), 2);
        fill_good(601);
        run("R9 restart", 0);

        finished = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule